// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is a digital model of the feedback and reference dividers in the first loop of a frequency synthesizer. A dual-modulus prescaler divides the oscillator input by P+1 or by P, as a modulus-control signal selects. A swallow counter and a main counter steer that control so that one output pulse appears every P×N + A oscillator cycles. A separate reference counter divides the reference input by R. Both divided pulses go to a phase comparator, so the locked output frequency is (P×N + A)·f_ref / R.

Both inputs are treated as digital events. Each clock cycle that has `vco_tick_i` or `ref_tick_i` high counts as one cycle of the oscillator or of the reference. Settings arrive through two load strobes. A legal setting takes effect at the divider's next terminal count, so a period is never cut short. An illegal setting raises an error flag and leaves the running ratio in place.

Top module: `pswallow_div`

## Requirements
- R1: With `psel_i`=0 the prescaler modulus P is 64, and with `psel_i`=1 it is 128. After a legal setting takes effect, consecutive `vco_div_o` pulses are exactly P×N + A oscillator ticks apart.
- R2: `mod_hi_o` (modulus control, 1 = divide by P+1) is high during the first A prescaler cycles of every output period and low for the remaining N − A cycles. Over one period it is therefore high for exactly A×(P+1) ticks, and it never goes high when A = 0.
- R3: After a legal R takes effect, consecutive `ref_div_o` pulses are exactly R reference ticks apart.
- R4: Each divider output pulse is one clock cycle wide. It is asserted in the clock cycle after the edge that consumes the tick completing the count.
- R5: A legal setting loaded in the middle of a period does not change that period. The period then running finishes at the old ratio, and the new ratio starts with the next period.
- R6: An oscillator setting with N < 5, N ≤ A, or A ≥ P is rejected. It sets `vco_err_o` and the previous ratio stays in use. A later legal oscillator load clears `vco_err_o`.
- R7: A reference setting with R < 5 is rejected. It sets `ref_err_o` and the previous R stays in use. A later legal reference load clears `ref_err_o`.
- R8: During reset and straight after it, both outputs and both error flags are low, and `mod_hi_o` is low. The reset ratios are P=64, N=5, A=0 (320 ticks) and R=5.
- R9: Clock cycles without a tick do not advance either divider, so the intervals in R1 to R3 hold in ticks whatever the gaps between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vco_tick_i | input | 1 | One oscillator input cycle |
| ref_tick_i | input | 1 | One reference input cycle |
| psel_i | input | 1 | Prescaler modulus select: 0 gives 64/65, 1 gives 128/129 |
| n_i | input | 11 | Main counter value N |
| a_i | input | 7 | Swallow counter value A |
| r_i | input | 14 | Reference divide value R |
| load_vco_i | input | 1 | Capture psel_i, n_i, a_i |
| load_ref_i | input | 1 | Capture r_i |
| vco_div_o | output | 1 | Divided oscillator pulse |
| ref_div_o | output | 1 | Divided reference pulse |
| mod_hi_o | output | 1 | Prescaler modulus control, 1 = divide by P+1 |
| vco_err_o | output | 1 | Last oscillator load was rejected |
| ref_err_o | output | 1 | Last reference load was rejected |

## Verification
The single-cycle pulse assertions assume that each period lasts at least two clock cycles. The legality checks guarantee this: R is at least 5 and the shortest oscillator period is 320 ticks. The counter-bound assertions assume that the active setting changes only at a terminal count, and that every value reaching the active slot has passed the legality test. The stimulus holds all setting inputs steady apart from single-cycle load strobes. It spaces ticks with regular gaps of one to three clocks, and it writes illegal values only to check rejection.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int DEF_A_W = 7;
  localparam int DEF_N_W = 11;
  localparam int DEF_R_W = 14;
  localparam int DEF_P_LO = 64;
  localparam int DEF_P_HI = 128;
  localparam int DEF_MIN_N = 5;
  localparam int DEF_MIN_R = 5;

  typedef enum logic {MOD_LO = 1'b0, MOD_HI = 1'b1} mod_sel_e;
endpackage

// File: rtl/psw_cfg_slot.sv
module psw_cfg_slot #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         legal_i,
  input  logic [W-1:0] data_i,
  input  logic         apply_i,
  output logic [W-1:0] act_o,
  output logic         err_o
);
  logic [W-1:0] pend_q;
  logic         pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= RST_VAL;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (load_i) err_o <= !legal_i;
      if (apply_i) begin
        // a load landing on the terminal count is taken at once
        if (load_i && legal_i) act_o <= data_i;
        else if (pend_v_q)     act_o <= pend_q;
        pend_v_q <= 1'b0;
      end else if (load_i && legal_i) begin
        pend_q   <= data_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  // rejection flag; also covers R7 on the reference instance
  assert_reject_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !legal_i) |=> err_o);
  assert_act_at_term_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(act_o));
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler import pswallow_pkg::*; #(
  parameter int P_LO = DEF_P_LO,
  parameter int P_HI = DEF_P_HI
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic psel_i,
  input  logic mod_hi_i,
  output logic cyc_done_o
);
  localparam int PC_W = $clog2(P_HI + 1);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last;

  always_comb begin
    last = ((psel_i == MOD_HI) ? PC_W'(P_HI) : PC_W'(P_LO)) - PC_W'(1) + PC_W'(mod_hi_i);
    cyc_done_o = tick_i && (pc_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= '0;
    else if (cyc_done_o) pc_q <= '0;
    else if (tick_i)     pc_q <= pc_q + PC_W'(1);
  end

  assert_pc_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pc_q) <= P_HI);
endmodule

// File: rtl/psw_swallow_ctr.sv
module psw_swallow_ctr import pswallow_pkg::*; #(
  parameter int A_W = DEF_A_W,
  parameter int N_W = DEF_N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cyc_done_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  output logic           mod_hi_o,
  output logic           term_o
);
  logic [N_W-1:0] main_q;
  logic [A_W-1:0] sw_q;

  assign mod_hi_o = sw_q < a_i;
  assign term_o   = cyc_done_i && (main_q == n_i - N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      sw_q   <= '0;
    end else if (term_o) begin
      main_q <= '0;
      sw_q   <= '0;
    end else if (cyc_done_i) begin
      main_q <= main_q + N_W'(1);
      if (mod_hi_o) sw_q <= sw_q + A_W'(1);
    end
  end

  assert_sw_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_q <= a_i);
  assert_mod_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_hi_o) |-> (main_q == '0));
  assert_main_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_q < n_i);
endmodule

// File: rtl/psw_ref_ctr.sv
module psw_ref_ctr import pswallow_pkg::*; #(
  parameter int R_W = DEF_R_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [R_W-1:0] r_i,
  output logic           done_o
);
  logic [R_W-1:0] rc_q;

  assign done_o = tick_i && (rc_q == r_i - R_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rc_q <= '0;
    else if (done_o) rc_q <= '0;
    else if (tick_i) rc_q <= rc_q + R_W'(1);
  end

  assert_rc_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_q < r_i);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div import pswallow_pkg::*; #(
  parameter int A_W   = DEF_A_W,
  parameter int N_W   = DEF_N_W,
  parameter int R_W   = DEF_R_W,
  parameter int P_LO  = DEF_P_LO,
  parameter int P_HI  = DEF_P_HI,
  parameter int MIN_N = DEF_MIN_N,
  parameter int MIN_R = DEF_MIN_R,
  parameter bit RST_PSEL = 1'b0,
  parameter int RST_N = 5,
  parameter int RST_A = 0,
  parameter int RST_R = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vco_tick_i,
  input  logic           ref_tick_i,
  input  logic           psel_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic [R_W-1:0] r_i,
  input  logic           load_vco_i,
  input  logic           load_ref_i,
  output logic           vco_div_o,
  output logic           ref_div_o,
  output logic           mod_hi_o,
  output logic           vco_err_o,
  output logic           ref_err_o
);
  localparam int VW = 1 + N_W + A_W;
  localparam logic [VW-1:0] VCO_RST = {RST_PSEL, N_W'(RST_N), A_W'(RST_A)};

  logic [VW-1:0]  vcfg_act;
  logic [R_W-1:0] r_act;
  logic           vco_legal, ref_legal;
  logic           cyc_done, vco_term, ref_done;
  logic           psel_act;
  logic [N_W-1:0] n_act;
  logic [A_W-1:0] a_act;

  assign vco_legal = (n_i >= N_W'(MIN_N)) && (n_i > N_W'(a_i))
                   && (32'(a_i) < (psel_i ? 32'(P_HI) : 32'(P_LO)));
  assign ref_legal = r_i >= R_W'(MIN_R);
  assign {psel_act, n_act, a_act} = vcfg_act;

  psw_cfg_slot #(.W(VW), .RST_VAL(VCO_RST)) i_vco_slot (
    .clk_i, .rst_ni,
    .load_i (load_vco_i),
    .legal_i(vco_legal),
    .data_i ({psel_i, n_i, a_i}),
    .apply_i(vco_term),
    .act_o  (vcfg_act),
    .err_o  (vco_err_o)
  );

  psw_cfg_slot #(.W(R_W), .RST_VAL(R_W'(RST_R))) i_ref_slot (
    .clk_i, .rst_ni,
    .load_i (load_ref_i),
    .legal_i(ref_legal),
    .data_i (r_i),
    .apply_i(ref_done),
    .act_o  (r_act),
    .err_o  (ref_err_o)
  );

  psw_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) i_presc (
    .clk_i, .rst_ni,
    .tick_i    (vco_tick_i),
    .psel_i    (psel_act),
    .mod_hi_i  (mod_hi_o),
    .cyc_done_o(cyc_done)
  );

  psw_swallow_ctr #(.A_W(A_W), .N_W(N_W)) i_swallow (
    .clk_i, .rst_ni,
    .cyc_done_i(cyc_done),
    .n_i       (n_act),
    .a_i       (a_act),
    .mod_hi_o  (mod_hi_o),
    .term_o    (vco_term)
  );

  psw_ref_ctr #(.R_W(R_W)) i_refdiv (
    .clk_i, .rst_ni,
    .tick_i(ref_tick_i),
    .r_i   (r_act),
    .done_o(ref_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vco_div_o <= 1'b0;
      ref_div_o <= 1'b0;
    end else begin
      vco_div_o <= vco_term;
      ref_div_o <= ref_done;
    end
  end

  assert_vco_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_div_o |=> !vco_div_o);
  assert_ref_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_div_o |=> !ref_div_o);
  assert_ref_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ref_i && (r_i < R_W'(MIN_R))) |=> ref_err_o);
  assert_active_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_act > N_W'(a_act)) && (n_act >= N_W'(MIN_N)) && (r_act >= R_W'(MIN_R)));
endmodule

// File: tb/test_pswallow_div.sv
module test_pswallow_div;
  localparam int LIMIT = 190000;
  localparam int NV = 6;
  localparam int V_PSEL[NV] = '{0, 0, 1, 0, 1, 1};
  localparam int V_N[NV]    = '{5, 10, 6, 64, 5, 20};
  localparam int V_A[NV]    = '{0, 3, 5, 63, 4, 0};
  localparam int V_R[NV]    = '{5, 384, 17, 100, 16, 6};
  localparam int V_GAP[NV]  = '{1, 1, 2, 1, 1, 3};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vco_tick_i = 1'b0, ref_tick_i = 1'b0, psel_i = 1'b0;
  logic [10:0] n_i = '0;
  logic [6:0]  a_i = '0;
  logic [13:0] r_i = '0;
  logic load_vco_i = 1'b0, load_ref_i = 1'b0;
  logic vco_div_o, ref_div_o, mod_hi_o, vco_err_o, ref_err_o;

  always #10 clk = ~clk;

  pswallow_div i_pswallow_div (
    .clk_i(clk), .rst_ni, .vco_tick_i, .ref_tick_i, .psel_i, .n_i, .a_i, .r_i,
    .load_vco_i, .load_ref_i, .vco_div_o, .ref_div_o, .mod_hi_o, .vco_err_o, .ref_err_o
  );

  int checks = 0, failures = 0;
  int nsteps = 0, phase = 0, gap = 1;
  bit timeout = 1'b0;
  int vcnt = 0, hcnt = 0, rcnt = 0;
  int vint = 0, vhi = 0, rint = 0;
  int vpulses = 0, rpulses = 0, dbl = 0;
  bit vprev = 1'b0, rprev = 1'b0;
  int cur_v = 320, cur_hi = 0, cur_r = 5;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit lv, input bit lr);
    bit t;
    @(negedge clk);
    if (vco_div_o) begin
      if (vprev) dbl++;
      vint = vcnt; vhi = hcnt; vcnt = 0; hcnt = 0; vpulses++;
    end
    if (ref_div_o) begin
      if (rprev) dbl++;
      rint = rcnt; rcnt = 0; rpulses++;
    end
    vprev = vco_div_o; rprev = ref_div_o;
    phase++;
    t = (phase % gap) == 0;
    vco_tick_i = t; ref_tick_i = t;
    load_vco_i = lv; load_ref_i = lr;
    if (t) begin
      vcnt++; rcnt++;
      if (mod_hi_o) hcnt++;
    end
    nsteps++;
    if (nsteps > LIMIT) timeout = 1'b1;
  endtask

  task automatic measure(input bit lv, input bit lr, input int ov, input int nv,
                         input int hi, input int orr, input int nr, input string tag);
    int v0, r0;
    int v1g = -1, v2g = -1, h2 = -1, r1g = -1, r2g = -1;
    step(lv, lr);
    v0 = vpulses; r0 = rpulses;
    while (!timeout && (vpulses < v0 + 2 || rpulses < r0 + 2)) begin
      step(1'b0, 1'b0);
      if (vpulses == v0 + 1 && v1g < 0) v1g = vint;
      if (vpulses == v0 + 2 && v2g < 0) begin v2g = vint; h2 = vhi; end
      if (rpulses == r0 + 1 && r1g < 0) r1g = rint;
      if (rpulses == r0 + 2 && r2g < 0) r2g = rint;
    end
    check(v1g == ov, {"R5 vco old period ", tag}, v1g, ov);
    check(v2g == nv, {"R1 vco ratio ", tag}, v2g, nv);
    check(h2 == hi, {"R2 modulus-high ticks ", tag}, h2, hi);
    check(r1g == orr, {"R5 ref old period ", tag}, r1g, orr);
    check(r2g == nr, {"R3 ref ratio ", tag}, r2g, nr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!vco_div_o && !ref_div_o && !mod_hi_o, "R8 outputs in reset",
          {vco_div_o, ref_div_o, mod_hi_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!vco_err_o && !ref_err_o && !mod_hi_o && !vco_div_o, "R8 after reset",
          {vco_err_o, ref_err_o, mod_hi_o, vco_div_o}, 0);

    // table: each vector loads both dividers
    for (int i = 0; i < NV; i++) begin
      int p, nv, hi;
      p = (V_PSEL[i] != 0) ? 128 : 64;
      nv = p * V_N[i] + V_A[i];
      hi = V_A[i] * (p + 1);
      gap = V_GAP[i];
      psel_i = V_PSEL[i][0]; n_i = 11'(V_N[i]); a_i = 7'(V_A[i]); r_i = 14'(V_R[i]);
      measure(1'b1, 1'b1, cur_v, nv, hi, cur_r, V_R[i], $sformatf("vec%0d gap%0d R9", i, gap));
      check(!vco_err_o && !ref_err_o, "R6 legal load no error", {vco_err_o, ref_err_o}, 0);
      cur_v = nv; cur_hi = hi; cur_r = V_R[i];
    end

    gap = 1;
    // rejected oscillator settings
    psel_i = 1'b0; n_i = 11'd4; a_i = 7'd0;
    measure(1'b1, 1'b0, cur_v, cur_v, cur_hi, cur_r, cur_r, "N below min");
    check(vco_err_o == 1'b1, "R6 err on N<5", vco_err_o, 1);
    psel_i = 1'b0; n_i = 11'd7; a_i = 7'd7;
    measure(1'b1, 1'b0, cur_v, cur_v, cur_hi, cur_r, cur_r, "N equals A");
    check(vco_err_o == 1'b1, "R6 err on N<=A", vco_err_o, 1);
    psel_i = 1'b0; n_i = 11'd100; a_i = 7'd64;
    measure(1'b1, 1'b0, cur_v, cur_v, cur_hi, cur_r, cur_r, "A at P");
    check(vco_err_o == 1'b1, "R6 err on A>=P", vco_err_o, 1);

    // rejected then accepted reference
    r_i = 14'd4;
    measure(1'b0, 1'b1, cur_v, cur_v, cur_hi, cur_r, cur_r, "R below min");
    check(ref_err_o == 1'b1, "R7 err on R<5", ref_err_o, 1);
    r_i = 14'd384;
    measure(1'b0, 1'b1, cur_v, cur_v, cur_hi, cur_r, 384, "R 384");
    check(ref_err_o == 1'b0, "R7 legal load clears", ref_err_o, 0);
    cur_r = 384;

    // largest swallow value, clears oscillator error
    psel_i = 1'b1; n_i = 11'd128; a_i = 7'd127;
    measure(1'b1, 1'b0, cur_v, 128 * 128 + 127, 127 * 129, cur_r, cur_r, "A max");
    check(vco_err_o == 1'b0, "R6 legal load clears", vco_err_o, 0);

    check(dbl == 0, "R4 single-cycle pulses", dbl, 0);
    check(!timeout, "R1 watchdog", nsteps, LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule